// File: doc/BRIEF.md
# Three-Wire Handshake Link Controller

This block is the host end of a turn-based, byte-serial link to a small peripheral controller. An external shift register moves the bytes. It tells this block when each byte has finished shifting, and this block tells it which way to shift. Three active-low handshake lines pace the traffic. The device owns a request line. The host drives an in-progress line and an acknowledge line. The acknowledge line changes level once for each byte rather than pulsing.

A five-state machine runs the link: listen, receive, receive-end, send-start and send. It moves one step on each byte-complete strobe. Packets from the device go into a 16-byte buffer and leave through a packet port as a one-cycle pulse together with a length.

The host loads outgoing packets through a command port. The command is either an arbitrary 2 to 8 byte packet or the built-in 3-byte auto-poll command, which turns polling on or off. A send whose first byte meets a device request is abandoned. The packet stays queued and is tried again once the request line is released.

Top module: `hs_link_ctrl`

## Requirements
- R1: After reset the machine is in listen. `tip_no` and `ack_no` are both high, `sr_dir_out_o` is 0 (input), and `cmd_busy_o` and `pkt_valid_o` are 0. In listen, `tip_no` and `ack_no` are always high.
- R2: In listen, a byte strobe with `req_ni` low starts reception. `tip_no` goes low on the next cycle and that byte is not stored. A strobe in listen with `req_ni` high changes no output.
- R3: In receive, each strobe stores `sr_rdata_i` as the next packet byte. If `req_ni` is low at that strobe, `ack_no` inverts.
- R4: A receive strobe with `req_ni` high stores its byte, drives `ack_no` and `tip_no` high, and moves to receive-end.
- R5: In receive-end, a strobe discards its byte and pulses `pkt_valid_o` for one cycle. `pkt_len_o` gives the byte count, and byte k of the packet sits at `pkt_data_o[8k+7:8k]`. If `req_ni` is low, `tip_no` goes low and reception continues with no discarded lead byte; otherwise the machine returns to listen.
- R6: Bytes past the 16th byte of a packet are dropped. `pkt_len_o` saturates at 16 and the first 16 bytes are kept.
- R7: A send starts only in listen, with a packet queued, `req_ni` high and no strobe in that cycle. On the next cycle `sr_dir_out_o` is 1, `tip_no` is low, and `sr_load_o` pulses with byte 0 on `sr_wdata_o`.
- R8: In send-start, a strobe with `req_ni` low is a collision. `sr_dir_out_o` returns to 0, `tip_no` and `ack_no` go high, the machine returns to listen and `cmd_busy_o` stays 1. The send restarts from byte 0 once `req_ni` is high.
- R9: Each later strobe of a send loads the next byte in order with a `sr_load_o` pulse and inverts `ack_no`. The strobe after the last byte sets `sr_dir_out_o` to 0, drives `tip_no` and `ack_no` high and clears `cmd_busy_o`.
- R10: A command with `cmd_autopoll_i` set queues the three bytes 0x01, 0x01, then 0x01 if `cmd_ap_en_i` is 1 or 0x00 if it is 0.
- R11: `cmd_busy_o` is 1 while a packet is queued. A command given while it is 1 is ignored. A non-auto-poll command with `cmd_len_i` outside 2..8 is also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_evt_i | input | 1 | One-cycle strobe: shift register finished a byte |
| req_ni | input | 1 | Device request, active low |
| sr_rdata_i | input | 8 | Byte shifted in by the device |
| tip_no | output | 1 | Transaction in progress, active low |
| ack_no | output | 1 | Acknowledge, inverts once per byte |
| sr_dir_out_o | output | 1 | Shift direction, 1 = host to device |
| sr_load_o | output | 1 | One-cycle strobe: load `sr_wdata_o` into the shift register |
| sr_wdata_o | output | 8 | Byte to transmit |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_autopoll_i | input | 1 | Queue the built-in auto-poll command |
| cmd_ap_en_i | input | 1 | Auto-poll enable value |
| cmd_len_i | input | 4 | Packet length, 2..8 |
| cmd_data_i | input | 64 | Packet bytes, byte k at bits 8k+7:8k |
| cmd_busy_o | output | 1 | A packet is queued |
| pkt_valid_o | output | 1 | One-cycle strobe: received packet delivered |
| pkt_len_o | output | 5 | Received byte count, saturated at 16 |
| pkt_data_o | output | 128 | Received bytes, byte k at bits 8k+7:8k |

## Verification
The hardest case to reach is a collision. The device has to assert its request in exactly the window between the host loading byte 0 and the first byte strobe. Otherwise the host sees the request early and does not start the send at all. The stimulus queues a packet with the request released, waits one cycle for the load pulse, then drops the request just before the strobe. It then holds the request low for a while to confirm that no retry happens, and finally releases it to watch the whole packet go out from byte 0. Back-to-back reception and the overlong packet come from keeping the request low across the receive-end strobe and from driving 20 bytes into the 16-byte buffer.

// File: rtl/hs_link_pkg.sv
package hs_link_pkg;
  typedef enum logic [2:0] {
    ST_LISTEN,
    ST_RECV,
    ST_REND,
    ST_SSTART,
    ST_SEND
  } hs_state_e;

  localparam logic [7:0] AP_PKT_TYPE = 8'h01;
  localparam logic [7:0] AP_CMD_CODE = 8'h01;
endpackage

// File: rtl/hs_rx_buf.sv
module hs_rx_buf #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic [7:0]           wdata_i,
  input  logic                 clr_i,
  output logic [CW-1:0]        cnt_o,
  output logic [DEPTH*8-1:0]   data_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (wr_i && cnt_q < CW'(DEPTH)) cnt_q <= cnt_q + CW'(1);
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) data_o[g*8 +: 8] <= '0;
      else if (wr_i && cnt_q == CW'(g)) data_o[g*8 +: 8] <= wdata_i;
    end
  end

  assign cnt_o = cnt_q;

  AST_RX_LEN_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !clr_i && cnt_q == CW'(DEPTH)) |=> (cnt_q == CW'(DEPTH))); // R6
endmodule

// File: rtl/hs_tx_queue.sv
module hs_tx_queue #(
  parameter int DEPTH = 8,
  localparam int LW = $clog2(DEPTH + 1),
  localparam int IW = $clog2(DEPTH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               push_i,
  input  logic [LW-1:0]      len_i,
  input  logic [DEPTH*8-1:0] data_i,
  input  logic               done_i,
  input  logic [IW-1:0]      sel_i,
  output logic               pending_o,
  output logic [LW-1:0]      len_o,
  output logic [7:0]         byte_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_o <= 1'b0;
      len_o     <= '0;
    end else if (push_i) begin
      pending_o <= 1'b1;
      len_o     <= len_i;
    end else if (done_i) begin
      pending_o <= 1'b0;
      len_o     <= '0;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[g] <= '0;
      else if (push_i) mem_q[g] <= data_i[g*8 +: 8];
    end
  end

  assign byte_o = mem_q[sel_i];

  AST_PUSH_ONLY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !pending_o); // R11
endmodule

// File: rtl/hs_link_ctrl.sv
module hs_link_ctrl
  import hs_link_pkg::*;
#(
  parameter int RX_DEPTH = 16,
  parameter int TX_DEPTH = 8,
  localparam int RX_CW = $clog2(RX_DEPTH + 1),
  localparam int TX_LW = $clog2(TX_DEPTH + 1),
  localparam int TX_IW = $clog2(TX_DEPTH)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  byte_evt_i,
  input  logic                  req_ni,
  input  logic [7:0]            sr_rdata_i,
  output logic                  tip_no,
  output logic                  ack_no,
  output logic                  sr_dir_out_o,
  output logic                  sr_load_o,
  output logic [7:0]            sr_wdata_o,
  input  logic                  cmd_valid_i,
  input  logic                  cmd_autopoll_i,
  input  logic                  cmd_ap_en_i,
  input  logic [TX_LW-1:0]      cmd_len_i,
  input  logic [TX_DEPTH*8-1:0] cmd_data_i,
  output logic                  cmd_busy_o,
  output logic                  pkt_valid_o,
  output logic [RX_CW-1:0]      pkt_len_o,
  output logic [RX_DEPTH*8-1:0] pkt_data_o
);
  hs_state_e         state_q;
  logic [TX_LW-1:0]  idx_q;
  logic              tx_pending, tx_push, tx_done, send_go;
  logic [TX_LW-1:0]  tx_len, push_len;
  logic [TX_DEPTH*8-1:0] push_data;
  logic [TX_IW-1:0]  tx_sel;
  logic [7:0]        tx_byte;
  logic              rx_wr, rx_clr;
  logic [RX_CW-1:0]  rx_cnt;
  logic              len_ok;

  // command acceptance
  assign len_ok  = cmd_len_i >= TX_LW'(2) && cmd_len_i <= TX_LW'(TX_DEPTH);
  assign tx_push = cmd_valid_i && !tx_pending && (cmd_autopoll_i || len_ok);

  always_comb begin
    push_data = cmd_data_i;
    push_len  = cmd_len_i;
    if (cmd_autopoll_i) begin
      push_data       = '0;
      push_data[7:0]  = AP_PKT_TYPE;
      push_data[15:8] = AP_CMD_CODE;
      push_data[23:16] = {7'd0, cmd_ap_en_i};
      push_len        = TX_LW'(3);
    end
  end

  assign send_go = state_q == ST_LISTEN && !byte_evt_i && tx_pending && req_ni;
  assign tx_done = byte_evt_i && state_q == ST_SEND && idx_q >= tx_len;
  assign rx_wr   = byte_evt_i && state_q == ST_RECV;
  assign rx_clr  = byte_evt_i && state_q == ST_REND;

  always_comb begin
    case (state_q)
      ST_LISTEN: tx_sel = '0;
      ST_SSTART: tx_sel = TX_IW'(1);
      default:   tx_sel = idx_q[TX_IW-1:0];
    endcase
  end

  hs_tx_queue #(.DEPTH(TX_DEPTH)) u_txq (
    .clk_i, .rst_ni,
    .push_i(tx_push), .len_i(push_len), .data_i(push_data),
    .done_i(tx_done), .sel_i(tx_sel),
    .pending_o(tx_pending), .len_o(tx_len), .byte_o(tx_byte)
  );

  hs_rx_buf #(.DEPTH(RX_DEPTH)) u_rxb (
    .clk_i, .rst_ni,
    .wr_i(rx_wr), .wdata_i(sr_rdata_i), .clr_i(rx_clr),
    .cnt_o(rx_cnt), .data_o(pkt_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_LISTEN;
      tip_no       <= 1'b1;
      ack_no       <= 1'b1;
      sr_dir_out_o <= 1'b0;
      sr_load_o    <= 1'b0;
      sr_wdata_o   <= '0;
      idx_q        <= '0;
      pkt_valid_o  <= 1'b0;
      pkt_len_o    <= '0;
    end else begin
      sr_load_o   <= 1'b0;
      pkt_valid_o <= 1'b0;
      case (state_q)
        ST_LISTEN: begin
          if (byte_evt_i) begin
            if (!req_ni) begin  // lead byte discarded
              tip_no  <= 1'b0;
              state_q <= ST_RECV;
            end
          end else if (send_go) begin
            sr_dir_out_o <= 1'b1;
            sr_load_o    <= 1'b1;
            sr_wdata_o   <= tx_byte;
            tip_no       <= 1'b0;
            state_q      <= ST_SSTART;
          end
        end
        ST_RECV: if (byte_evt_i) begin
          if (!req_ni) ack_no <= ~ack_no;
          else begin
            ack_no  <= 1'b1;
            tip_no  <= 1'b1;
            state_q <= ST_REND;
          end
        end
        ST_REND: if (byte_evt_i) begin
          pkt_valid_o <= 1'b1;
          pkt_len_o   <= rx_cnt;
          if (!req_ni) begin
            tip_no  <= 1'b0;
            state_q <= ST_RECV;
          end else state_q <= ST_LISTEN;
        end
        ST_SSTART: if (byte_evt_i) begin
          if (!req_ni) begin  // collision: back off, keep packet queued
            sr_dir_out_o <= 1'b0;
            tip_no       <= 1'b1;
            ack_no       <= 1'b1;
            state_q      <= ST_LISTEN;
          end else begin
            sr_load_o  <= 1'b1;
            sr_wdata_o <= tx_byte;
            ack_no     <= ~ack_no;
            idx_q      <= TX_LW'(2);
            state_q    <= ST_SEND;
          end
        end
        ST_SEND: if (byte_evt_i) begin
          if (idx_q < tx_len) begin
            sr_load_o  <= 1'b1;
            sr_wdata_o <= tx_byte;
            ack_no     <= ~ack_no;
            idx_q      <= idx_q + TX_LW'(1);
          end else begin
            sr_dir_out_o <= 1'b0;
            ack_no       <= 1'b1;
            tip_no       <= 1'b1;
            idx_q        <= '0;
            state_q      <= ST_LISTEN;
          end
        end
        default: state_q <= ST_LISTEN;
      endcase
    end
  end

  assign cmd_busy_o = tx_pending;

  AST_IDLE_LINES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LISTEN) |-> (tip_no && ack_no)); // R1
  AST_RX_ACK_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RECV && byte_evt_i && !req_ni) |=> (ack_no != $past(ack_no))); // R3
  AST_DELIVER_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_o |=> !pkt_valid_o); // R5
  AST_START_NEEDS_REQ_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SSTART && $past(state_q) == ST_LISTEN) |-> $past(req_ni)); // R7
  AST_SEND_DIR_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SSTART || state_q == ST_SEND) |-> (sr_dir_out_o && !tip_no)); // R7
  AST_COLLISION_KEEPS_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SSTART && byte_evt_i && !req_ni) |=> (cmd_busy_o && !sr_dir_out_o)); // R8
endmodule

// File: tb/hs_link_ctrl_tb_top.sv
`timescale 1ns/1ps
module hs_link_ctrl_tb_top;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic byte_evt = 1'b0, req_n = 1'b1;
  logic [7:0] rdata = '0;
  logic tip_n, ack_n, dir_out, load;
  logic [7:0] wdata;
  logic cmd_valid = 1'b0, cmd_ap = 1'b0, cmd_en = 1'b0;
  logic [3:0] cmd_len = '0;
  logic [63:0] cmd_data = '0;
  logic busy, pkt_valid;
  logic [4:0] pkt_len;
  logic [127:0] pkt_data;
  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic exp_ack;

  always #2 clk = ~clk;

  hs_link_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .byte_evt_i(byte_evt), .req_ni(req_n),
    .sr_rdata_i(rdata), .tip_no(tip_n), .ack_no(ack_n), .sr_dir_out_o(dir_out),
    .sr_load_o(load), .sr_wdata_o(wdata), .cmd_valid_i(cmd_valid),
    .cmd_autopoll_i(cmd_ap), .cmd_ap_en_i(cmd_en), .cmd_len_i(cmd_len),
    .cmd_data_i(cmd_data), .cmd_busy_o(busy), .pkt_valid_o(pkt_valid),
    .pkt_len_o(pkt_len), .pkt_data_o(pkt_data)
  );

  // {bytes driven, expected length}
  localparam int RX_TAB [4][2] = '{'{1, 1}, '{3, 3}, '{16, 16}, '{20, 16}};

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic evt(logic [7:0] d);
    @(negedge clk); byte_evt = 1'b1; rdata = d;
    @(negedge clk); byte_evt = 1'b0;
  endtask

  task automatic cmd(bit ap, bit en, int len, logic [63:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_ap = ap; cmd_en = en; cmd_len = 4'(len); cmd_data = d;
    @(negedge clk); cmd_valid = 1'b0; cmd_ap = 1'b0;
  endtask

  task automatic rx_pkt(int n, int exp_len, logic [7:0] base, bit btb_in, bit btb_out);
    if (!btb_in) begin
      req_n = 1'b0;
      evt(8'hEE);
      chk(tip_n == 1'b0, "R2 start tip", int'(tip_n), 0);
    end
    exp_ack = 1'b1;
    for (int i = 0; i < n; i++) begin
      if (i == n - 1) req_n = 1'b1;
      evt(base + 8'(i));
      if (i < n - 1) begin
        exp_ack = ~exp_ack;
        chk(ack_n == exp_ack, "R3 ack toggle", int'(ack_n), int'(exp_ack));
      end else
        chk(ack_n && tip_n, "R4 lines high at last byte", int'({tip_n, ack_n}), 3);
    end
    req_n = btb_out ? 1'b0 : 1'b1;
    evt(8'hDD);
    chk(pkt_valid == 1'b1, "R5 pkt_valid", int'(pkt_valid), 1);
    chk(int'(pkt_len) == exp_len, "R5 R6 pkt_len", int'(pkt_len), exp_len);
    for (int k = 0; k < exp_len; k++)
      chk(pkt_data[k*8 +: 8] == base + 8'(k), "R5 R6 pkt byte",
          int'(pkt_data[k*8 +: 8]), int'(base + 8'(k)));
    chk(tip_n == !btb_out, "R5 tip after end", int'(tip_n), int'(!btb_out));
    @(negedge clk);
    chk(pkt_valid == 1'b0, "R5 pulse width", int'(pkt_valid), 0);
  endtask

  // expects a queued packet with req_n high; send starts at next edge
  task automatic tx_pkt(int len, logic [63:0] d, string tag);
    @(negedge clk);
    chk(load && wdata == d[7:0] && dir_out && !tip_n, {tag, " R7 start"},
        int'({load, dir_out, tip_n, wdata}), int'({3'b110, d[7:0]}));
    exp_ack = 1'b1;
    for (int i = 1; i < len; i++) begin
      evt(8'h00);
      exp_ack = ~exp_ack;
      chk(load && wdata == d[i*8 +: 8] && ack_n == exp_ack, {tag, " R9 byte"},
          int'({load, ack_n, wdata}), int'({1'b1, exp_ack, d[i*8 +: 8]}));
    end
    evt(8'h00);
    chk(!dir_out && tip_n && ack_n && !busy, {tag, " R9 end"},
        int'({dir_out, tip_n, ack_n, busy}), 6);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(tip_n && ack_n && !dir_out && !busy && !pkt_valid, "R1 reset state",
        int'({tip_n, ack_n, dir_out, busy, pkt_valid}), 5'b11000);

    // R2: strobe in listen with request high is ignored
    req_n = 1'b1;
    evt(8'h55);
    chk(tip_n && ack_n && !pkt_valid, "R2 ignored strobe", int'({tip_n, ack_n, pkt_valid}), 6);

    // receive table
    for (int t = 0; t < 4; t++)
      rx_pkt(RX_TAB[t][0], RX_TAB[t][1], 8'(8'h10 * (t + 1)), 1'b0, 1'b0);

    // R5: back-to-back packets
    rx_pkt(2, 2, 8'hA0, 1'b0, 1'b1);
    rx_pkt(3, 3, 8'hB0, 1'b1, 1'b0);

    // R7 R9: plain send
    req_n = 1'b1;
    cmd(1'b0, 1'b0, 4, 64'h0000_0000_4433_2211);
    chk(busy == 1'b1, "R11 busy after accept", int'(busy), 1);
    tx_pkt(4, 64'h0000_0000_4433_2211, "send4");

    // R10: auto-poll enable and disable
    cmd(1'b1, 1'b1, 0, 64'hFFFF_FFFF_FFFF_FFFF);
    tx_pkt(3, 64'h01_01_01, "R10 ap on");
    cmd(1'b1, 1'b0, 0, '0);
    tx_pkt(3, 64'h00_01_01, "R10 ap off");

    // R8: collision on first byte, then retry
    cmd(1'b0, 1'b0, 2, 64'h0000_0000_0000_BBAA);
    @(negedge clk);
    chk(load && dir_out, "R7 start before collision", int'({load, dir_out}), 3);
    req_n = 1'b0;
    evt(8'h00);
    chk(!dir_out && tip_n && ack_n && busy, "R8 collision backoff",
        int'({dir_out, tip_n, ack_n, busy}), 4'b0111);
    repeat (3) @(negedge clk);
    chk(tip_n && !dir_out && !load, "R7 no start while req low", int'({tip_n, dir_out, load}), 4);
    req_n = 1'b1;
    tx_pkt(2, 64'h0000_0000_0000_BBAA, "R8 retry");

    // R11: command while busy is ignored
    req_n = 1'b0;
    cmd(1'b0, 1'b0, 2, 64'h0000_0000_0000_2C1C);
    cmd(1'b0, 1'b0, 3, 64'h0000_0000_0077_6655);
    chk(busy == 1'b1, "R11 still busy", int'(busy), 1);
    req_n = 1'b1;
    tx_pkt(2, 64'h0000_0000_0000_2C1C, "R11 first kept");

    // R11: illegal lengths refused
    cmd(1'b0, 1'b0, 1, 64'h99);
    chk(busy == 1'b0, "R11 len 1 refused", int'(busy), 0);
    @(negedge clk);
    chk(load == 1'b0 && tip_n, "R11 no send len 1", int'({load, tip_n}), 1);
    cmd(1'b0, 1'b0, 9, 64'h99);
    chk(busy == 1'b0, "R11 len 9 refused", int'(busy), 0);

    // R1: reset in the middle of a send
    cmd(1'b0, 1'b0, 3, 64'h0000_0000_0033_2211);
    @(negedge clk);
    evt(8'h00);
    rst_ni = 1'b0;
    @(negedge clk);
    chk(tip_n && ack_n && !dir_out && !busy, "R1 mid-send reset",
        int'({tip_n, ack_n, dir_out, busy}), 4'b1100);
    rst_ni = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule